// File: doc/BRIEF.md
# AHB-Lite Register File Slave

This block is a small memory-mapped register file that sits on an AHB-Lite bus as a zero-wait-state slave. It holds three 32-bit words: a control word that software reads and writes, a status word that hardware fills and software can only read, and a display word made of four 7-bit segment digits, each with its own decimal-point bit. Each word is built from generic field storage cells, and every cell has the same two ports: a bus side and a hardware side. Field outputs and hardware write ports are brought out to the surrounding logic.

A small bus front end keeps all protocol handling away from the cells. It samples the address phase of a valid transfer and moves to one of three states. `PH_IDLE` means no transfer is in its data phase. `PH_WRITE` means a write data phase is under way: the selected word's cells receive a bus write enable and take HWDATA. `PH_READ` means a read data phase is under way: the selected word's cells receive a one-cycle bus read enable and return their contents onto HRDATA. At every clock edge the next state is chosen from the current bus inputs alone. A valid write leads to `PH_WRITE`, a valid read leads to `PH_READ`, and anything else leads to `PH_IDLE`. Any state can reach any state.

Word offsets are 0x00 for control, 0x04 for status and 0x08 for display. Address bits [1:0] are not used for decoding. Every other offset is unmapped.

Top module: `ahb_regfile`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0, every display digit output is 0, every decimal-point output is 1, and the display word reads 0x80808080.
- R2: HREADYOUT is always 1 and HRESP is always 0 (OKAY), so every transfer finishes with no wait state.
- R3: A write to offset 0x00 stores HWDATA from the data phase. The `ctrl_q` output shows the new value one clock after the data phase, and a later read of 0x00 returns it.
- R4: A bus write to offset 0x04 leaves the status word unchanged. A hardware write (`stat_hw_we` high for one clock) stores `stat_hw_din`, and a read of 0x04 returns it.
- R5: In the display word, digit k (k = 0..3) sits in bits [8k+6:8k] and appears on `disp_digit_q[7k+6:7k]`. Its decimal point sits in bit 8k+7 and appears on `disp_point_q[k]`. Bus writes and hardware writes update all eight fields, and a read returns them in the same bit positions.
- R6: A read from an unmapped offset (word index 3 or higher) returns 0. A write to an unmapped offset changes no register.
- R7: The block ignores any transfer for which HSEL is low, HTRANS is IDLE (00) or BUSY (01), or HREADY is low. Such a transfer writes nothing and leaves HRDATA at 0 in the following cycle.
- R8: When a bus write and a hardware write reach the control word or the display word in the same clock, the bus data is stored. A hardware write on its own is stored.
- R9: HRDATA carries the selected word only in the data phase of a read, and is 0 at all other times. A read whose address phase lines up with the data phase of a write to the same word returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address |
| htrans | input | 2 | Transfer type (NONSEQ 10, SEQ 11 are valid) |
| hwrite | input | 1 | 1 = write, 0 = read |
| hready | input | 1 | Previous transfer complete on the bus |
| hwdata | input | 32 | Write data, used in the data phase |
| hrdata | output | 32 | Read data, driven in the read data phase |
| hreadyout | output | 1 | Always 1 |
| hresp | output | 1 | Always 0 (OKAY) |
| ctrl_hw_we | input | 1 | Hardware write enable for the control word |
| ctrl_hw_din | input | 32 | Hardware write data for the control word |
| ctrl_q | output | 32 | Control word contents |
| stat_hw_we | input | 1 | Hardware write enable for the status word |
| stat_hw_din | input | 32 | Hardware write data for the status word |
| stat_q | output | 32 | Status word contents |
| disp_hw_we | input | 1 | Hardware write enable for the display word |
| disp_hw_din | input | 32 | Hardware write data, in display word layout |
| disp_digit_q | output | DIGITS*DIGIT_W | Segment digits, packed, digit 0 in the low bits |
| disp_point_q | output | DIGITS | Decimal-point bits, one per digit |

## Verification
A wrong phase state or a stale captured address shows up in the very next cycle. Read data appears on HRDATA when it should be zero, comes from the wrong word, or is missing. A write lands in a neighbouring word, and its field output changes one clock after the data phase. A field cell with the wrong access kind or the wrong priority shows up one clock after the conflicting write, on that word's field output. A mistake in the display field layout shows up at once when the word is read back, as bits moved out of place. The bench keeps its own model of all three words and compares every field output after each operation, so a corrupted register is caught within a single operation.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 3;
    localparam int REG_CTRL = 0;
    localparam int REG_STAT = 1;
    localparam int REG_DISP = 2;

    localparam logic [1:0] HTRANS_IDLE   = 2'b00;
    localparam logic [1:0] HTRANS_BUSY   = 2'b01;
    localparam logic [1:0] HTRANS_NONSEQ = 2'b10;

    // Data-phase state of the bus front end.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } bus_phase_t;

    // How the bus side may touch a field cell.
    typedef enum logic {
        CELL_RW = 1'b0,
        CELL_RO = 1'b1
    } cell_kind_t;

endpackage

// File: rtl/rf_field_cell.sv
module rf_field_cell
    import regfile_pkg::*;
#(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter cell_kind_t KIND    = CELL_RW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [W-1:0] bus_din,
    input  logic         bus_re,
    output logic [W-1:0] bus_dout,
    input  logic         hw_we,
    input  logic [W-1:0] hw_din,
    output logic [W-1:0] q
);

    generate
        if (KIND == CELL_RW) begin : g_rw
            // Bus write takes priority over a hardware write in the same cycle.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= RST_VAL;
                end else if (bus_we) begin
                    q <= bus_din;
                end else if (hw_we) begin
                    q <= hw_din;
                end
            end
        end else begin : g_ro
            logic unused_bus_side;
            assign unused_bus_side = ^{bus_we, bus_din};

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= RST_VAL;
                end else if (hw_we) begin
                    q <= hw_din;
                end
            end
        end
    endgenerate

    // Read return is zero unless this cell's word is being read.
    assign bus_dout = bus_re ? q : '0;

endmodule

// File: rtl/regfile_bus_fsm.sv
module regfile_bus_fsm
    import regfile_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              hsel,
    input  logic [ADDR_W-1:0]                 haddr,
    input  logic [1:0]                        htrans,
    input  logic                              hwrite,
    input  logic                              hready,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]   rd_words,
    output logic [NUM_REGS-1:0]               reg_we,
    output logic [NUM_REGS-1:0]               reg_re,
    output logic [DATA_W-1:0]                 hrdata,
    output bus_phase_t                        phase
);

    localparam int WIDX_W = ADDR_W - 2;

    bus_phase_t        state_q;
    bus_phase_t        state_d;
    logic [WIDX_W-1:0] widx_q;
    logic [NUM_REGS-1:0] hit;
    logic              xfer_ok;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{haddr[1:0], htrans[0]};

    // NONSEQ and SEQ both have htrans[1] set.
    assign xfer_ok = hsel && htrans[1] && hready;

    // Next-state selection from the current address phase.
    always_comb begin
        unique case ({xfer_ok, hwrite})
            2'b11:   state_d = PH_WRITE;
            2'b10:   state_d = PH_READ;
            default: state_d = PH_IDLE;
        endcase
    end

    // State register and captured word index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            widx_q  <= '0;
        end else begin
            state_q <= state_d;
            if (xfer_ok) begin
                widx_q <= haddr[ADDR_W-1:2];
            end
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_dec
            assign hit[gi] = (widx_q == WIDX_W'(gi));
        end
    endgenerate

    // Per-state strobes to the field cells.
    always_comb begin
        reg_we = '0;
        reg_re = '0;
        unique case (state_q)
            PH_WRITE: reg_we = hit;
            PH_READ:  reg_re = hit;
            PH_IDLE:  ;
            default:  ;
        endcase
    end

    // Cells return zero unless read-enabled, so an OR forms the read mux.
    always_comb begin
        hrdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            hrdata = hrdata | rd_words[i];
        end
    end

    assign phase = state_q;

endmodule

// File: rtl/ahb_regfile.sv
module ahb_regfile
    import regfile_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DIGITS  = 4,
    parameter int DIGIT_W = 7
) (
    input  logic                        hclk,
    input  logic                        hresetn,
    input  logic                        hsel,
    input  logic [ADDR_W-1:0]           haddr,
    input  logic [1:0]                  htrans,
    input  logic                        hwrite,
    input  logic                        hready,
    input  logic [31:0]                 hwdata,
    output logic [31:0]                 hrdata,
    output logic                        hreadyout,
    output logic                        hresp,
    input  logic                        ctrl_hw_we,
    input  logic [31:0]                 ctrl_hw_din,
    output logic [31:0]                 ctrl_q,
    input  logic                        stat_hw_we,
    input  logic [31:0]                 stat_hw_din,
    output logic [31:0]                 stat_q,
    input  logic                        disp_hw_we,
    input  logic [31:0]                 disp_hw_din,
    output logic [DIGITS*DIGIT_W-1:0]   disp_digit_q,
    output logic [DIGITS-1:0]           disp_point_q
);

    localparam int SLOT_W = DIGIT_W + 1;

    logic [NUM_REGS-1:0]             reg_we;
    logic [NUM_REGS-1:0]             reg_re;
    logic [NUM_REGS-1:0][DATA_W-1:0] rd_words;
    bus_phase_t                      bus_phase;

    assign hreadyout = 1'b1;
    assign hresp     = 1'b0;

    regfile_bus_fsm #(
        .ADDR_W (ADDR_W)
    ) u_bus (
        .clk      (hclk),
        .rst_n    (hresetn),
        .hsel     (hsel),
        .haddr    (haddr),
        .htrans   (htrans),
        .hwrite   (hwrite),
        .hready   (hready),
        .rd_words (rd_words),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .hrdata   (hrdata),
        .phase    (bus_phase)
    );

    // Control word: one full-width read/write field.
    rf_field_cell #(
        .W       (DATA_W),
        .RST_VAL ('0),
        .KIND    (CELL_RW)
    ) u_ctrl (
        .clk      (hclk),
        .rst_n    (hresetn),
        .bus_we   (reg_we[REG_CTRL]),
        .bus_din  (hwdata),
        .bus_re   (reg_re[REG_CTRL]),
        .bus_dout (rd_words[REG_CTRL]),
        .hw_we    (ctrl_hw_we),
        .hw_din   (ctrl_hw_din),
        .q        (ctrl_q)
    );

    // Status word: hardware-written, bus read only.
    rf_field_cell #(
        .W       (DATA_W),
        .RST_VAL ('0),
        .KIND    (CELL_RO)
    ) u_stat (
        .clk      (hclk),
        .rst_n    (hresetn),
        .bus_we   (reg_we[REG_STAT]),
        .bus_din  (hwdata),
        .bus_re   (reg_re[REG_STAT]),
        .bus_dout (rd_words[REG_STAT]),
        .hw_we    (stat_hw_we),
        .hw_din   (stat_hw_din),
        .q        (stat_q)
    );

    // Display word: one digit field and one point field per slot.
    genvar gd;
    generate
        for (gd = 0; gd < DIGITS; gd++) begin : g_disp
            rf_field_cell #(
                .W       (DIGIT_W),
                .RST_VAL ('0),
                .KIND    (CELL_RW)
            ) u_digit (
                .clk      (hclk),
                .rst_n    (hresetn),
                .bus_we   (reg_we[REG_DISP]),
                .bus_din  (hwdata[gd*SLOT_W +: DIGIT_W]),
                .bus_re   (reg_re[REG_DISP]),
                .bus_dout (rd_words[REG_DISP][gd*SLOT_W +: DIGIT_W]),
                .hw_we    (disp_hw_we),
                .hw_din   (disp_hw_din[gd*SLOT_W +: DIGIT_W]),
                .q        (disp_digit_q[gd*DIGIT_W +: DIGIT_W])
            );

            rf_field_cell #(
                .W       (1),
                .RST_VAL (1'b1),
                .KIND    (CELL_RW)
            ) u_point (
                .clk      (hclk),
                .rst_n    (hresetn),
                .bus_we   (reg_we[REG_DISP]),
                .bus_din  (hwdata[gd*SLOT_W + DIGIT_W]),
                .bus_re   (reg_re[REG_DISP]),
                .bus_dout (rd_words[REG_DISP][gd*SLOT_W + DIGIT_W]),
                .hw_we    (disp_hw_we),
                .hw_din   (disp_hw_din[gd*SLOT_W + DIGIT_W]),
                .q        (disp_point_q[gd])
            );
        end
    endgenerate

endmodule

// File: rtl/regfile_checker.sv
module regfile_checker
    import regfile_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsel,
    input logic [ADDR_W-1:0] haddr,
    input logic [1:0]        htrans,
    input logic              hready,
    input logic [31:0]       hwdata,
    input logic [31:0]       hrdata,
    input logic              hreadyout,
    input logic              hresp,
    input logic [31:0]       ctrl_q,
    input logic [31:0]       stat_q,
    input logic              stat_hw_we,
    input logic              ctrl_bus_we,
    input bus_phase_t        phase
);

    // R2
    zero_wait_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hreadyout && !hresp);

    // R4
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_hw_we |=> $stable(stat_q));

    // R8
    ctrl_bus_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_bus_we |=> ctrl_q == $past(hwdata));

    // R9
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase != PH_READ |-> hrdata == 32'h0);

    // R7
    ignored_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hsel && htrans[1] && hready) |=> phase == PH_IDLE);

    // R6
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ && $past(haddr[ADDR_W-1:2]) >= (ADDR_W-2)'(NUM_REGS))
        |-> hrdata == 32'h0);

endmodule

bind ahb_regfile regfile_checker #(.ADDR_W(ADDR_W)) u_regfile_chk (
    .clk         (hclk),
    .rst_n       (hresetn),
    .hsel        (hsel),
    .haddr       (haddr),
    .htrans      (htrans),
    .hready      (hready),
    .hwdata      (hwdata),
    .hrdata      (hrdata),
    .hreadyout   (hreadyout),
    .hresp       (hresp),
    .ctrl_q      (ctrl_q),
    .stat_q      (stat_q),
    .stat_hw_we  (stat_hw_we),
    .ctrl_bus_we (reg_we[regfile_pkg::REG_CTRL]),
    .phase       (bus_phase)
);

// File: tb/tb_ahb_regfile.sv
module tb_ahb_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int DIGITS     = 4;
    localparam int DIGIT_W    = 7;

    logic              hclk = 1'b0;
    logic              hresetn = 1'b0;
    logic              hsel = 1'b0;
    logic [ADDR_W-1:0] haddr = '0;
    logic [1:0]        htrans = 2'b00;
    logic              hwrite = 1'b0;
    logic              hready = 1'b1;
    logic [31:0]       hwdata = '0;
    logic [31:0]       hrdata;
    logic              hreadyout;
    logic              hresp;
    logic              ctrl_hw_we = 1'b0;
    logic [31:0]       ctrl_hw_din = '0;
    logic [31:0]       ctrl_q;
    logic              stat_hw_we = 1'b0;
    logic [31:0]       stat_hw_din = '0;
    logic [31:0]       stat_q;
    logic              disp_hw_we = 1'b0;
    logic [31:0]       disp_hw_din = '0;
    logic [DIGITS*DIGIT_W-1:0] disp_digit_q;
    logic [DIGITS-1:0]         disp_point_q;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [31:0] m_ctrl;
    logic [31:0] m_stat;
    logic [31:0] m_disp;

    always #(CLK_PERIOD/2) hclk = ~hclk;

    ahb_regfile #(.ADDR_W(ADDR_W), .DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) dut (
        .hclk, .hresetn, .hsel, .haddr, .htrans, .hwrite, .hready, .hwdata,
        .hrdata, .hreadyout, .hresp,
        .ctrl_hw_we, .ctrl_hw_din, .ctrl_q,
        .stat_hw_we, .stat_hw_din, .stat_q,
        .disp_hw_we, .disp_hw_din, .disp_digit_q, .disp_point_q
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
        case (a[ADDR_W-1:2])
            6'd0:    return m_ctrl;
            6'd1:    return m_stat;
            6'd2:    return m_disp;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [27:0] digits_of(input logic [31:0] w);
        logic [27:0] d;
        for (int k = 0; k < 4; k++) d[7*k +: 7] = w[8*k +: 7];
        return d;
    endfunction

    function automatic logic [3:0] points_of(input logic [31:0] w);
        logic [3:0] p;
        for (int k = 0; k < 4; k++) p[k] = w[8*k+7];
        return p;
    endfunction

    task automatic check_outputs(input string req);
        check({req, " ctrl_q"}, ctrl_q, m_ctrl);
        check({req, " stat_q"}, stat_q, m_stat);
        check({req, " digits"}, {4'h0, disp_digit_q}, {4'h0, digits_of(m_disp)});
        check({req, " points"}, {28'h0, disp_point_q}, {28'h0, points_of(m_disp)});
        check("R2 ready/okay", {30'h0, hreadyout, hresp}, 32'h2);
    endtask

    // Starts and ends at a negedge with bus idle.
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                             input bit hw_ctrl, input logic [31:0] hwv);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = a; hready = 1'b1;
        @(posedge hclk); @(negedge hclk);
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = d;
        ctrl_hw_we = hw_ctrl; ctrl_hw_din = hwv;
        @(posedge hclk); @(negedge hclk);
        ctrl_hw_we = 1'b0;
        case (a[ADDR_W-1:2])
            6'd0: m_ctrl = d;
            6'd2: m_disp = d;
            default: ;
        endcase
        if (hw_ctrl && a[ADDR_W-1:2] != 6'd0) m_ctrl = hwv;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; haddr = a; hready = 1'b1;
        @(posedge hclk); @(negedge hclk);
        hsel = 1'b0; htrans = 2'b00;
        d = hrdata;
    endtask

    task automatic hw_write(input int which, input logic [31:0] v);
        case (which)
            0: begin ctrl_hw_we = 1'b1; ctrl_hw_din = v; end
            1: begin stat_hw_we = 1'b1; stat_hw_din = v; end
            default: begin disp_hw_we = 1'b1; disp_hw_din = v; end
        endcase
        @(posedge hclk); @(negedge hclk);
        ctrl_hw_we = 1'b0; stat_hw_we = 1'b0; disp_hw_we = 1'b0;
        case (which)
            0: m_ctrl = v;
            1: m_stat = v;
            default: m_disp = v;
        endcase
    endtask

    // kind 0: hsel low, 1: BUSY, 2: IDLE, 3: hready low
    task automatic ignored_xfer(input int kind, input logic [ADDR_W-1:0] a,
                                input logic [31:0] d, input bit wr);
        hsel = (kind != 0); htrans = (kind == 1) ? 2'b01 : (kind == 2) ? 2'b00 : 2'b10;
        hready = (kind != 3); hwrite = wr; haddr = a;
        @(posedge hclk); @(negedge hclk);
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hready = 1'b1; hwdata = d;
        check("R7 ignored transfer hrdata", hrdata, 32'h0);
        @(posedge hclk); @(negedge hclk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'h1234_5EED));
        m_ctrl = 32'h0; m_stat = 32'h0; m_disp = 32'h8080_8080;
        repeat (3) @(negedge hclk);
        hresetn = 1'b1;
        @(negedge hclk);

        // R1 reset state
        check_outputs("R1 reset");
        bus_read(8'h00, rd); check("R1 ctrl reset read", rd, 32'h0);
        bus_read(8'h04, rd); check("R1 stat reset read", rd, 32'h0);
        bus_read(8'h08, rd); check("R1 disp reset read", rd, 32'h8080_8080);

        // R3 control write and readback
        bus_write(8'h00, 32'hDEAD_BEEF, 1'b0, 32'h0);
        check("R3 ctrl_q after write", ctrl_q, 32'hDEAD_BEEF);
        bus_read(8'h00, rd); check("R3 ctrl readback", rd, 32'hDEAD_BEEF);

        // R4 status ignores bus write, takes hardware write
        bus_write(8'h04, 32'hFFFF_FFFF, 1'b0, 32'h0);
        check("R4 stat after bus write", stat_q, 32'h0);
        hw_write(1, 32'h1357_9BDF);
        bus_read(8'h04, rd); check("R4 stat readback", rd, 32'h1357_9BDF);

        // R5 display layout
        bus_write(8'h08, 32'h7F00_2A55, 1'b0, 32'h0);
        check_outputs("R5 disp bus write");
        bus_read(8'h08, rd); check("R5 disp readback", rd, 32'h7F00_2A55);
        hw_write(2, 32'h80FF_0103);
        check_outputs("R5 disp hw write");
        bus_read(8'h0A, rd); check("R5 disp readback low bits ignored", rd, 32'h80FF_0103);

        // R6 unmapped
        bus_write(8'h0C, 32'h1111_1111, 1'b0, 32'h0);
        bus_write(8'hFC, 32'h2222_2222, 1'b0, 32'h0);
        check_outputs("R6 unmapped write");
        bus_read(8'h0C, rd); check("R6 unmapped read 0x0C", rd, 32'h0);
        bus_read(8'h40, rd); check("R6 unmapped read 0x40", rd, 32'h0);

        // R7 ignored transfers
        for (int k = 0; k < 4; k++) begin
            ignored_xfer(k, 8'h00, 32'h5A5A_0000 + k, 1'b1);
            check_outputs("R7 ignored write");
            ignored_xfer(k, 8'h04, 32'h0, 1'b0);
        end

        // R8 priority
        bus_write(8'h00, 32'hA5A5_A5A5, 1'b1, 32'h0F0F_0F0F);
        check("R8 bus beats hw on ctrl", ctrl_q, 32'hA5A5_A5A5);
        hw_write(0, 32'h0F0F_0F0F);
        check("R8 hw alone on ctrl", ctrl_q, 32'h0F0F_0F0F);

        // R9 read in the data phase of a write to the same word
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 8'h00;
        @(posedge hclk); @(negedge hclk);
        hwdata = 32'hC0DE_CAFE; hwrite = 1'b0;
        @(posedge hclk); @(negedge hclk);
        hsel = 1'b0; htrans = 2'b00;
        m_ctrl = 32'hC0DE_CAFE;
        check("R9 read after write", hrdata, 32'hC0DE_CAFE);
        @(posedge hclk); @(negedge hclk);
        check("R9 hrdata zero outside read", hrdata, 32'h0);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [ADDR_W-1:0] a;
            logic [31:0] v;
            op = $urandom_range(0, 5);
            a  = ADDR_W'($urandom_range(0, 5) * 4 + $urandom_range(0, 3));
            v  = $urandom;
            case (op)
                0, 1: bus_write(a, v, ($urandom_range(0, 3) == 0), $urandom);
                2, 3: begin
                    bus_read(a, rd);
                    check("R9 random read", rd, model_read(a));
                end
                4: hw_write($urandom_range(0, 2), v);
                default: ignored_xfer($urandom_range(0, 3), a, v, $urandom_range(0, 1) == 1);
            endcase
            check_outputs("R3/R5/R8 random state");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule